// File: doc/BRIEF.md
# Pointer-Addressed Serial Peripheral Register Port

This block sits between a host bus and a two-channel serial peripheral. The host drives active-low read, write and chip-enable strobes with no timing relation to the block clock, together with a channel select, a data/control select and an 8-bit data bus. Inside, each channel has sixteen write locations, with one alternate location behind write location 7, and sixteen read locations. Write locations are kept in a local register file and also announced on a one-cycle write port. Read locations are fetched from the serial engines through a one-cycle read port, unless a remapped location is read back from the local file.

Control accesses reach a register in two steps. A write to location 0 loads one pointer that both channels share. The next control access, read or write, uses the pointed location, and the pointer then returns to zero. An access with the data/control select high goes straight to the data buffer location and leaves the pointer alone. Driving read and write low together causes a hardware reset. This reset holds for a few clock cycles after release and clears the pointer and the register file.

Top module: `sio_regport`

## Requirements
- R1: A control write (dc_sel=0) while the pointer is 0 loads the pointer from din[2:0]; the next control access uses that location, which wp_addr or rp_addr shows.
- R2: If din[5:3] equals 3'b001 in the pointer-loading write, the pointer gets 8 added, so locations 8 to 15 can be reached.
- R3: After any control access, read or write, the pointer is 0, so the following control write lands on location 0.
- R4: An access with dc_sel=1 goes to location 8: a read raises rp_stb with rp_addr=8, and a write raises wp_stb with wp_addr=8. The pointer does not change.
- R5: The level of ch_sel (0 for channel 0, 1 for channel 1) during the access itself picks the channel shown on wp_chan or rp_chan. The pointer is common to both channels.
- R6: While cs_n is high, falling read or write strobes have no effect: no port strobe and no pointer change.
- R7: rd_n and wr_n low together raise hw_rst at any cs_n level. hw_rst stays high for 4 cycles after both synchronized strobes are high again. It clears the pointer and every stored location, and no access is taken while it is high.
- R8: When bit 0 of the channel's location 15 is set, a write aimed at location 7 goes to the alternate location and raises wp_alt. Otherwise wp_alt stays 0.
- R9: When bit 6 of the channel's alternate location is set, reads of locations 9, 11 and 14 return the stored write locations 3 and 10 and the alternate location, in that pairing. rp_stb is not raised for these reads.
- R10: A strobe falling edge seen within 3 cycles of a taken access is ignored. One seen 4 cycles later is taken.
- R11: After reset, dout is 0, hw_rst is 0 and no port strobe is active.
- R12: A read that is not remapped loads rp_data, sampled while rp_stb is high, into dout. dout holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low |
| cs_n | input | 1 | Chip enable, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| ch_sel | input | 1 | Channel select (0 = channel 0) |
| dc_sel | input | 1 | 1 = data buffer access, 0 = pointer-addressed access |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data, held until the next read |
| hw_rst | output | 1 | Internal reset from the strobe-coincidence condition |
| wp_stb | output | 1 | One-cycle write-port strobe |
| wp_chan | output | 1 | Channel of the write |
| wp_alt | output | 1 | Write went to the alternate location |
| wp_addr | output | 4 | Written location |
| wp_data | output | 8 | Written value |
| rp_stb | output | 1 | One-cycle read-port strobe |
| rp_chan | output | 1 | Channel of the read |
| rp_addr | output | 4 | Read location |
| rp_data | input | 8 | Read value returned by the engines in the strobe cycle |

## Verification
A vector table runs a fixed sequence of accesses through the pointer. It mixes pointer loads with and without the point-high code, writes and reads on both channels, and data-path accesses placed between a pointer load and its use. This tells a pointer that returns to zero apart from one that lingers, and a pointer that data accesses leave alone apart from one they disturb. Directed tests then set up the alternate-location redirect and the read remap on one channel only, and separate the per-channel enable from a global one. Further tests place a second strobe 3 and 4 cycles after the first to find the recovery boundary. Others pulse strobes with chip enable high, and hold both strobes low to measure how long hw_rst lasts and what it clears.

// File: rtl/sio_regport_pkg.sv
package sio_regport_pkg;
    localparam int unsigned BUS_W          = 8;
    // command field of location 0 and the code that selects the upper bank
    localparam int unsigned CMD_LSB        = 3;
    localparam int unsigned CMD_W          = 3;
    localparam logic [2:0]  CMD_POINT_HIGH = 3'b001;
    // control bits inside stored locations
    localparam int unsigned ENH_BIT        = 0;
    localparam int unsigned RMAP_BIT       = 6;
    // read locations that are served from stored write locations
    localparam int unsigned RB_LOC_A       = 9;
    localparam int unsigned RB_SRC_A       = 3;
    localparam int unsigned RB_LOC_B       = 11;
    localparam int unsigned RB_SRC_B       = 10;
    localparam int unsigned RB_LOC_ALT     = 14;

    typedef struct packed {
        logic             vld;
        logic             rd;
        logic             ch;
        logic             dc;
        logic [BUS_W-1:0] data;
    } bus_acc_t;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int unsigned W    = 1,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.s1 = d;
        nxt_d.s2 = cur_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.s1 <= INIT;
            cur_q.s2 <= INIT;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign q = cur_q.s2;
endmodule

// File: rtl/sio_strobe_ctl.sv
module sio_strobe_ctl
    import sio_regport_pkg::*;
#(
    parameter int unsigned REC_CYC  = 3,
    parameter int unsigned RST_HOLD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_s,
    input  logic             rd_s,
    input  logic             wr_s,
    input  logic             ch,
    input  logic             dc,
    input  logic [BUS_W-1:0] din,
    output bus_acc_t         acc,
    output logic             hw_rst
);
    localparam int unsigned RW = $clog2(REC_CYC + 1);
    localparam int unsigned HW = $clog2(RST_HOLD + 1);

    typedef struct packed {
        logic          rd_prev;
        logic          wr_prev;
        logic [RW-1:0] rec;
        logic [HW-1:0] hold;
        logic          act;
        bus_acc_t      acc;
    } ctl_t;

    ctl_t cur_q, nxt_d;
    logic both_low, rd_fall, wr_fall, busy, take;

    always_comb begin
        nxt_d    = cur_q;
        both_low = !rd_s && !wr_s;
        rd_fall  = cur_q.rd_prev && !rd_s;
        wr_fall  = cur_q.wr_prev && !wr_s;
        busy     = cur_q.act || both_low || (cur_q.rec != '0);
        take     = !busy && !cs_s && (rd_fall || wr_fall);

        nxt_d.rd_prev  = rd_s;
        nxt_d.wr_prev  = wr_s;
        nxt_d.acc.vld  = take;
        nxt_d.acc.rd   = rd_fall;
        nxt_d.acc.ch   = ch;
        nxt_d.acc.dc   = dc;
        nxt_d.acc.data = din;

        if (take)                 nxt_d.rec = RW'(REC_CYC);
        else if (cur_q.rec != '0) nxt_d.rec = cur_q.rec - 1'b1;

        if (both_low)              nxt_d.hold = HW'(RST_HOLD);
        else if (cur_q.hold != '0) nxt_d.hold = cur_q.hold - 1'b1;
        nxt_d.act = both_low || (cur_q.hold != '0);
        if (cur_q.act) nxt_d.rec = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q         <= '0;
            cur_q.rd_prev <= 1'b1;
            cur_q.wr_prev <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign acc    = cur_q.acc;
    assign hw_rst = cur_q.act;
endmodule

// File: rtl/sio_regfile.sv
module sio_regfile
    import sio_regport_pkg::*;
#(
    parameter int unsigned NREG = 16,
    localparam int unsigned AW  = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  bus_acc_t         acc,
    input  logic [BUS_W-1:0] rp_data,
    output logic             wp_stb,
    output logic             wp_chan,
    output logic             wp_alt,
    output logic [AW-1:0]    wp_addr,
    output logic [BUS_W-1:0] wp_data,
    output logic             rp_stb,
    output logic             rp_chan,
    output logic [AW-1:0]    rp_addr,
    output logic [BUS_W-1:0] dout,
    output logic [AW-1:0]    ptr
);
    localparam logic [AW-1:0] L_DATA = AW'(NREG / 2);
    localparam logic [AW-1:0] L_ALT  = AW'(NREG / 2 - 1);
    localparam logic [AW-1:0] L_ENH  = AW'(NREG - 1);
    localparam logic [AW-1:0] L_RBA  = AW'(RB_LOC_A);
    localparam logic [AW-1:0] L_RBB  = AW'(RB_LOC_B);
    localparam logic [AW-1:0] L_RBT  = AW'(RB_LOC_ALT);
    localparam logic [AW-1:0] L_SRA  = AW'(RB_SRC_A);
    localparam logic [AW-1:0] L_SRB  = AW'(RB_SRC_B);

    typedef struct packed {
        logic [AW-1:0]                       ptr;
        logic [1:0][NREG-1:0][BUS_W-1:0]     wreg;
        logic [1:0][BUS_W-1:0]               alt;
        logic [BUS_W-1:0]                    dout;
    } rf_t;

    rf_t cur_q, nxt_d;
    logic [AW-1:0] tgt;
    logic          enh, rmap;

    always_comb begin
        nxt_d   = cur_q;
        tgt     = acc.dc ? L_DATA : cur_q.ptr;
        enh     = cur_q.wreg[acc.ch][L_ENH][ENH_BIT];
        rmap    = cur_q.alt[acc.ch][RMAP_BIT];
        wp_stb  = 1'b0;
        wp_alt  = 1'b0;
        wp_chan = acc.ch;
        wp_addr = tgt;
        wp_data = acc.data;
        rp_stb  = 1'b0;
        rp_chan = acc.ch;
        rp_addr = tgt;

        if (acc.vld && !acc.rd) begin
            wp_stb = 1'b1;
            if (!acc.dc && tgt == '0)
                nxt_d.ptr = {acc.data[CMD_LSB +: CMD_W] == CMD_POINT_HIGH,
                             acc.data[AW-2:0]};
            else if (!acc.dc)
                nxt_d.ptr = '0;
            if (tgt == L_ALT && enh) begin
                wp_alt               = 1'b1;
                nxt_d.alt[acc.ch]    = acc.data;
            end else begin
                nxt_d.wreg[acc.ch][tgt] = acc.data;
            end
        end else if (acc.vld && acc.rd) begin
            if (!acc.dc) nxt_d.ptr = '0;
            if (rmap && tgt == L_RBA)
                nxt_d.dout = cur_q.wreg[acc.ch][L_SRA];
            else if (rmap && tgt == L_RBB)
                nxt_d.dout = cur_q.wreg[acc.ch][L_SRB];
            else if (rmap && tgt == L_RBT)
                nxt_d.dout = cur_q.alt[acc.ch];
            else begin
                rp_stb     = 1'b1;
                nxt_d.dout = rp_data;
            end
        end

        if (clr) nxt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign dout = cur_q.dout;
    assign ptr  = cur_q.ptr;
endmodule

// File: rtl/sio_regport.sv
module sio_regport
    import sio_regport_pkg::*;
#(
    parameter int unsigned NREG     = 16,
    parameter int unsigned REC_CYC  = 3,
    parameter int unsigned RST_HOLD = 4,
    localparam int unsigned AW      = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             ch_sel,
    input  logic             dc_sel,
    input  logic [BUS_W-1:0] din,
    output logic [BUS_W-1:0] dout,
    output logic             hw_rst,
    output logic             wp_stb,
    output logic             wp_chan,
    output logic             wp_alt,
    output logic [AW-1:0]    wp_addr,
    output logic [BUS_W-1:0] wp_data,
    output logic             rp_stb,
    output logic             rp_chan,
    output logic [AW-1:0]    rp_addr,
    input  logic [BUS_W-1:0] rp_data
);
    logic [2:0]    strb_s;
    bus_acc_t      acc;
    logic          acc_vld, acc_dc;
    logic [AW-1:0] ptr_cur;

    sio_sync #(.W(3), .INIT(3'b111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, rd_n, wr_n}),
        .q     (strb_s)
    );

    sio_strobe_ctl #(.REC_CYC(REC_CYC), .RST_HOLD(RST_HOLD)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_s   (strb_s[2]),
        .rd_s   (strb_s[1]),
        .wr_s   (strb_s[0]),
        .ch     (ch_sel),
        .dc     (dc_sel),
        .din    (din),
        .acc    (acc),
        .hw_rst (hw_rst)
    );

    sio_regfile #(.NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hw_rst),
        .acc     (acc),
        .rp_data (rp_data),
        .wp_stb  (wp_stb),
        .wp_chan (wp_chan),
        .wp_alt  (wp_alt),
        .wp_addr (wp_addr),
        .wp_data (wp_data),
        .rp_stb  (rp_stb),
        .rp_chan (rp_chan),
        .rp_addr (rp_addr),
        .dout    (dout),
        .ptr     (ptr_cur)
    );

    assign acc_vld = acc.vld;
    assign acc_dc  = acc.dc;
endmodule

// File: rtl/sio_regport_chk.sv
module sio_regport_chk #(
    parameter int unsigned AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_vld,
    input logic          acc_dc,
    input logic [AW-1:0] ptr_cur,
    input logic          hw_rst,
    input logic          wp_stb,
    input logic          wp_alt,
    input logic [AW-1:0] wp_addr,
    input logic          rp_stb
);
    localparam logic [AW-1:0] L_ALT = AW'((1 << AW) / 2 - 1);

    p_one_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wp_stb && rp_stb));

    p_quiet_in_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hw_rst |-> !wp_stb && !rp_stb);

    p_gap1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld |=> !acc_vld);

    p_gap2_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_vld, 2) |-> !acc_vld);

    p_alt_loc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_stb && wp_alt) |-> wp_addr == L_ALT);

    p_ptr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !acc_dc && ptr_cur != '0) |=> ptr_cur == '0);

    p_data_keeps_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_dc && !hw_rst) |=> $stable(ptr_cur));
endmodule

bind sio_regport sio_regport_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_vld (acc_vld),
    .acc_dc  (acc_dc),
    .ptr_cur (ptr_cur),
    .hw_rst  (hw_rst),
    .wp_stb  (wp_stb),
    .wp_alt  (wp_alt),
    .wp_addr (wp_addr),
    .rp_stb  (rp_stb)
);

// File: tb/sio_regport_bench.sv
module sio_regport_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic       ch_sel = 1'b0, dc_sel = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout, wp_data, rp_data;
    logic       hw_rst, wp_stb, wp_chan, wp_alt, rp_stb, rp_chan;
    logic [3:0] wp_addr, rp_addr;

    int n_chk = 0, n_fail = 0, wcnt = 0, rcnt = 0;
    logic       lw_chan, lw_alt, lr_chan;
    logic [3:0] lw_addr, lr_addr;
    logic [7:0] lw_data;
    bit         done = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] model(input logic ch, input logic [3:0] a);
        return {ch, 3'b101, a};
    endfunction
    assign rp_data = model(rp_chan, rp_addr);

    sio_regport u_sio_regport (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .ch_sel(ch_sel), .dc_sel(dc_sel), .din(din), .dout(dout),
        .hw_rst(hw_rst), .wp_stb(wp_stb), .wp_chan(wp_chan), .wp_alt(wp_alt),
        .wp_addr(wp_addr), .wp_data(wp_data), .rp_stb(rp_stb),
        .rp_chan(rp_chan), .rp_addr(rp_addr), .rp_data(rp_data)
    );

    always @(negedge clk) begin
        if (wp_stb) begin
            wcnt++; lw_chan = wp_chan; lw_alt = wp_alt;
            lw_addr = wp_addr; lw_data = wp_data;
        end
        if (rp_stb) begin
            rcnt++; lr_chan = rp_chan; lr_addr = rp_addr;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic rd, input logic ch, input logic dc,
                          input logic [7:0] d, input logic ce_n = 1'b0);
        @(negedge clk);
        ch_sel = ch; dc_sel = dc; din = d; cs_n = ce_n;
        if (rd) rd_n = 1'b0; else wr_n = 1'b0;
        repeat (4) @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1; cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic two_writes(input logic [7:0] d1, input int gap, input logic [7:0] d2);
        @(negedge clk);
        ch_sel = 1'b0; dc_sel = 1'b0; din = d1; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        repeat (gap - 1) @(negedge clk);
        din = d2; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic wexp(input string tag, input int cnt0, input logic ch,
                        input logic [3:0] a, input logic alt, input logic [7:0] d);
        chk({tag, " count"}, wcnt, cnt0 + 1);
        chk({tag, " chan"}, lw_chan, ch);
        chk({tag, " addr"}, lw_addr, a);
        chk({tag, " alt"}, lw_alt, alt);
        chk({tag, " data"}, lw_data, d);
    endtask

    typedef struct packed {
        logic       rd;
        logic       ch;
        logic       dc;
        logic [7:0] d;
        logic [3:0] addr;
        logic [7:0] q;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b0, 1'b0, 8'h05, 4'd0,  8'h00},  // R1 load pointer 5
        '{1'b0, 1'b1, 1'b0, 8'hA3, 4'd5,  8'h00},  // R1 R5 ch1 hits location 5
        '{1'b0, 1'b0, 1'b0, 8'h5C, 4'd0,  8'h00},  // R3 back at 0, load 4
        '{1'b0, 1'b0, 1'b1, 8'h77, 4'd8,  8'h00},  // R4 data write
        '{1'b1, 1'b0, 1'b0, 8'h00, 4'd4,  8'h54},  // R4 R12 pointer kept
        '{1'b0, 1'b0, 1'b0, 8'h0B, 4'd0,  8'h00},  // R2 point-high, 3+8
        '{1'b0, 1'b1, 1'b0, 8'h42, 4'd11, 8'h00},  // R2 location 11 on ch1
        '{1'b1, 1'b1, 1'b1, 8'h00, 4'd8,  8'hD8},  // R4 data read
        '{1'b1, 1'b0, 1'b0, 8'h00, 4'd0,  8'h50}   // R3 read at 0
    };

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int w0, r0;
        repeat (4) @(negedge clk);
        chk("R11 dout", dout, 0);
        chk("R11 hw_rst", hw_rst, 0);
        chk("R11 strobes", {wp_stb, rp_stb}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 dout after release", dout, 0);

        for (int i = 0; i < NVEC; i++) begin
            w0 = wcnt; r0 = rcnt;
            access(VEC[i].rd, VEC[i].ch, VEC[i].dc, VEC[i].d);
            if (VEC[i].rd) begin
                chk("R12 vec read count", rcnt, r0 + 1);
                chk("R5 vec read chan", lr_chan, VEC[i].ch);
                chk("R1 vec read addr", lr_addr, VEC[i].addr);
                chk("R12 vec dout", dout, VEC[i].q);
            end else begin
                wexp("R1 vec write", w0, VEC[i].ch, VEC[i].addr, 1'b0, VEC[i].d);
            end
        end

        // R8 R9: enable redirect and remap on channel 0 only
        access(1'b0, 1'b0, 1'b0, 8'h0F); access(1'b0, 1'b0, 1'b0, 8'h01);
        access(1'b0, 1'b0, 1'b0, 8'h03); access(1'b0, 1'b0, 1'b0, 8'h3C);
        access(1'b0, 1'b0, 1'b0, 8'h0A); access(1'b0, 1'b0, 1'b0, 8'hA5);
        access(1'b0, 1'b0, 1'b0, 8'h07);
        w0 = wcnt;
        access(1'b0, 1'b0, 1'b0, 8'h40);
        wexp("R8 redirect", w0, 1'b0, 4'd7, 1'b1, 8'h40);
        access(1'b0, 1'b1, 1'b0, 8'h07);
        w0 = wcnt;
        access(1'b0, 1'b1, 1'b0, 8'h12);
        wexp("R8 no redirect ch1", w0, 1'b1, 4'd7, 1'b0, 8'h12);
        access(1'b0, 1'b0, 1'b0, 8'h09);
        r0 = rcnt; access(1'b1, 1'b0, 1'b0, 8'h00);
        chk("R9 loc9 dout", dout, 8'h3C); chk("R9 loc9 no port", rcnt, r0);
        access(1'b0, 1'b0, 1'b0, 8'h0B);
        access(1'b1, 1'b0, 1'b0, 8'h00);
        chk("R9 loc11 dout", dout, 8'hA5);
        access(1'b0, 1'b0, 1'b0, 8'h0E);
        access(1'b1, 1'b0, 1'b0, 8'h00);
        chk("R9 loc14 dout", dout, 8'h40); chk("R9 loc14 no port", rcnt, r0);

        // R6: strobes with chip enable high
        access(1'b0, 1'b0, 1'b0, 8'h02);
        w0 = wcnt; r0 = rcnt;
        access(1'b0, 1'b0, 1'b0, 8'h33, 1'b1);
        access(1'b1, 1'b0, 1'b0, 8'h00, 1'b1);
        chk("R6 no write", wcnt, w0); chk("R6 no read", rcnt, r0);
        access(1'b0, 1'b0, 1'b0, 8'h44);
        wexp("R6 pointer kept", w0, 1'b0, 4'd2, 1'b0, 8'h44);

        // R10: recovery window
        access(1'b1, 1'b0, 1'b0, 8'h00);
        w0 = wcnt;
        two_writes(8'h06, 3, 8'h55);
        wexp("R10 gap3 second ignored", w0, 1'b0, 4'd0, 1'b0, 8'h06);
        w0 = wcnt;
        access(1'b0, 1'b0, 1'b0, 8'h99);
        wexp("R10 pointer from first", w0, 1'b0, 4'd6, 1'b0, 8'h99);
        w0 = wcnt;
        two_writes(8'h01, 4, 8'h22);
        chk("R10 gap4 both taken", wcnt, w0 + 2);
        chk("R10 gap4 addr", lw_addr, 1); chk("R10 gap4 data", lw_data, 8'h22);

        // R7: hardware reset
        access(1'b0, 1'b0, 1'b0, 8'h05);
        w0 = wcnt; r0 = rcnt;
        @(negedge clk); rd_n = 1'b0; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 hw_rst asserted", hw_rst, 1);
        repeat (3) @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R7 hw_rst held", hw_rst, 1);
        @(negedge clk);
        chk("R7 hw_rst released", hw_rst, 0);
        chk("R7 no access", wcnt - w0 + rcnt - r0, 0);
        chk("R7 dout cleared", dout, 0);
        repeat (4) @(negedge clk);
        w0 = wcnt;
        access(1'b0, 1'b0, 1'b0, 8'h09);
        wexp("R7 pointer cleared", w0, 1'b0, 4'd0, 1'b0, 8'h09);
        r0 = rcnt;
        access(1'b1, 1'b0, 1'b0, 8'h00);
        chk("R7 remap cleared port", rcnt, r0 + 1);
        chk("R7 remap cleared addr", lr_addr, 9);
        chk("R7 remap cleared dout", dout, model(1'b0, 4'd9));

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule